// File: doc/BRIEF.md
# Fractional Sample Cadence Generator

This block decides, frame by frame, how many sample blocks a serial audio link running at a fixed 48 kHz frame rate should carry. Rates that are whole multiples of 48 kHz get the same block count in every frame. Rates in the 44.1 kHz family get a repeating cadence instead. The cadence has thirteen runs of sample-carrying units, and each run is followed by one empty unit. Over a full pattern this gives 147 samples per 160 units, which is exactly 44.1/48.

The block takes a one-cycle frame strobe and a rate code. For each strobe it registers a block count and a sample-present flag, which the link serializer uses for that frame. A rate code is adopted only at a pattern boundary. This means a running fractional cadence is never cut off mid-pattern. For the fixed rates, every frame counts as a boundary.

Top module: `frac_cadence_gen`

## Requirements
- R1: While `rst_n` is low, `blk_count` is 0 and `sample_valid` is 0. After release, the first strobe starts a new pattern using the rate code present at that strobe.
- R2: Both outputs change only at the rising clock edge that samples `frame_strobe` high. At every other edge they hold their value.
- R3: Rate codes 0, 1 and 2 give 1, 2 and 4 blocks in every frame. Code 7 behaves exactly like code 0.
- R4: Code 3 is the 44.1 kHz cadence with a unit of one frame. The pattern runs 12,11,11,12,11,11,12,11,11,12,11,11,11 frames of 1 block, and each run is followed by one frame of 0 blocks. The pattern is 160 frames long and carries 147 samples.
- R5: Code 4 uses the same cadence as code 3, but gives 2 blocks in each sample-carrying frame. This is 294 blocks per 160 frames.
- R6: Code 5 uses the same cadence with a unit of 2 frames. Only the first frame of a sample-carrying unit has 1 block. An empty unit is 2 frames of 0. The pattern is 320 frames long.
- R7: Code 6 uses the same cadence with a unit of 4 frames. Only the first frame of a sample-carrying unit has 1 block. The pattern is 640 frames long.
- R8: A new rate code is taken only at a strobe where the pattern position is at its start. Changes at any other time have no effect until the running pattern completes.
- R9: `sample_valid` is 1 exactly when `blk_count` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_strobe | input | 1 | One-cycle pulse per link frame |
| rate_sel | input | 3 | Rate code (see R3 to R7) |
| blk_count | output | 3 | Sample blocks to send in the current frame |
| sample_valid | output | 1 | Current frame carries at least one sample |

## Verification
The bench uses the default package constants: thirteen runs, a long run of 12, and units of up to four frames. With these values the longest pattern is 640 frames, so several complete patterns of every fractional rate fit in a short run. Block totals over whole patterns are checked against 147 samples per pattern. A mid-pattern rate change is checked to have no effect until the pattern wraps. The check then confirms that the new rate appears on the frame right after the wrap. Random rate changes and random gaps between strobes exercise the hold behaviour and the adoption of a rate at a pattern boundary.

// File: rtl/cad_pkg.sv
package cad_pkg;

  // Cadence shape: number of runs, length of a long run, spacing of long runs.
  localparam int CAD_RUNS       = 13;
  localparam int CAD_LONG_LEN   = 12;
  localparam int CAD_LONG_EVERY = 3;
  localparam int MAX_UNIT_LOG2  = 2;
  localparam int BLK_W          = 3;

  localparam int RUN_W  = $clog2(CAD_RUNS);
  localparam int SLOT_W = $clog2(CAD_LONG_LEN + 1);
  localparam int SUB_W  = MAX_UNIT_LOG2;

  typedef enum logic [2:0] {
    RS_48K    = 3'd0,
    RS_96K    = 3'd1,
    RS_192K   = 3'd2,
    RS_44K1   = 3'd3,
    RS_88K2   = 3'd4,
    RS_22K05  = 3'd5,
    RS_11K025 = 3'd6,
    RS_RSVD   = 3'd7
  } rate_e;

  // Length of run idx: long every CAD_LONG_EVERY runs, last run is short.
  function automatic logic [SLOT_W-1:0] run_len(input logic [RUN_W-1:0] idx);
    if ((int'(idx) < CAD_RUNS - 1) && ((int'(idx) % CAD_LONG_EVERY) == 0))
      return SLOT_W'(CAD_LONG_LEN);
    else
      return SLOT_W'(CAD_LONG_LEN - 1);
  endfunction

endpackage

// File: rtl/cad_rate_map.sv
module cad_rate_map
  import cad_pkg::*;
(
  input  rate_e              rate,
  output logic               frac,
  output logic [1:0]         unit_log2,
  output logic [BLK_W-1:0]   mult
);

  always_comb begin
    frac      = 1'b0;
    unit_log2 = 2'd0;
    mult      = BLK_W'(1);
    case (rate)
      RS_96K:    mult = BLK_W'(2);
      RS_192K:   mult = BLK_W'(4);
      RS_44K1:   frac = 1'b1;
      RS_88K2:   begin frac = 1'b1; mult = BLK_W'(2); end
      RS_22K05:  begin frac = 1'b1; unit_log2 = 2'd1; end
      RS_11K025: begin frac = 1'b1; unit_log2 = 2'd2; end
      default:   mult = BLK_W'(1);
    endcase
  end

endmodule

// File: rtl/cad_pattern_ctr.sv
module cad_pattern_ctr
  import cad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic [1:0] unit_log2,
  output logic       at_start,
  output logic       sample_slot
);

  logic [SUB_W-1:0]  sub_q,  sub_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [RUN_W-1:0]  run_q,  run_d;
  logic [SLOT_W-1:0] len;
  logic [SUB_W-1:0]  unit_last;

  always_comb begin
    unit_last = '0;
    for (int i = 0; i < SUB_W; i++)
      if (i < int'(unit_log2)) unit_last[i] = 1'b1;
  end

  assign len         = run_len(run_q);
  assign at_start    = (sub_q == '0) && (slot_q == '0) && (run_q == '0);
  assign sample_slot = (sub_q == '0) && (slot_q < len);

  always_comb begin
    sub_d  = sub_q;
    slot_d = slot_q;
    run_d  = run_q;
    if (advance) begin
      if (sub_q == unit_last) begin
        sub_d = '0;
        if (slot_q == len) begin
          slot_d = '0;
          run_d  = (run_q == RUN_W'(CAD_RUNS - 1)) ? '0 : run_q + 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      slot_q <= '0;
      run_q  <= '0;
    end else if (advance) begin
      sub_q  <= sub_d;
      slot_q <= slot_d;
      run_q  <= run_d;
    end
  end

  // R4: the position inside a run never passes the trailing empty unit.
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= len);

  // R4: the run index stays within the thirteen-run table.
  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) < CAD_RUNS);

  // R1: counters hold when no frame advances them.
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(run_q) && $stable(slot_q) && $stable(sub_q));

endmodule

// File: rtl/frac_cadence_gen.sv
module frac_cadence_gen
  import cad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_strobe,
  input  logic [2:0]       rate_sel,
  output logic [BLK_W-1:0] blk_count,
  output logic             sample_valid
);

  rate_e            active_q, active_d, eff_rate;
  logic             at_start, sample_slot;
  logic             frac;
  logic [1:0]       unit_log2;
  logic [BLK_W-1:0] mult;
  logic [BLK_W-1:0] blk_d;
  logic             valid_d;
  logic             advance;

  // A new rate code is adopted only at a pattern boundary.
  assign eff_rate = at_start ? rate_e'(rate_sel) : active_q;
  assign advance  = frame_strobe & frac;

  cad_rate_map i_map (
    .rate      (eff_rate),
    .frac      (frac),
    .unit_log2 (unit_log2),
    .mult      (mult)
  );

  cad_pattern_ctr i_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (advance),
    .unit_log2   (unit_log2),
    .at_start    (at_start),
    .sample_slot (sample_slot)
  );

  always_comb begin
    active_d = active_q;
    blk_d    = blk_count;
    valid_d  = sample_valid;
    if (frame_strobe) begin
      active_d = eff_rate;
      blk_d    = (!frac || sample_slot) ? mult : '0;
      valid_d  = !frac || sample_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= RS_48K;
      blk_count    <= '0;
      sample_valid <= 1'b0;
    end else if (frame_strobe) begin
      active_q     <= active_d;
      blk_count    <= blk_d;
      sample_valid <= valid_d;
    end
  end

  // R2: outputs hold between frame strobes.
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(blk_count) && $stable(sample_valid));

  // R9: the flag agrees with the registered count.
  a_r9_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid == (blk_count != '0));

  // R3: counts are only ever 0, 1, 2 or 4.
  a_r3_count_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blk_count));

  // R8: a strobe inside a running pattern keeps the adopted rate.
  a_r8_no_midswitch: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !at_start) |=> $stable(active_q));

endmodule

// File: tb/test_frac_cadence_gen.sv
`timescale 1ns/1ps
module test_frac_cadence_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_strobe = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic [2:0] blk_count;
  logic       sample_valid;

  int n_cmp = 0;
  int n_bad = 0;
  int m_pos = 0;
  int m_rate = 0;
  int last_exp = 0;
  int obs_sum;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frac_cadence_gen i_frac_cadence_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .rate_sel     (rate_sel),
    .blk_count    (blk_count),
    .sample_valid (sample_valid)
  );

  function automatic int is_frac(input int r);
    return (r >= 3 && r <= 6) ? 1 : 0;
  endfunction

  function automatic int period(input int r);
    case (r)
      3, 4: return 160;
      5:    return 320;
      6:    return 640;
      default: return 1;
    endcase
  endfunction

  function automatic string tag(input int r);
    case (r)
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic int exp_blk(input int r, input int pos);
    int u, mult, unit, len;
    if (!is_frac(r)) return (r == 1) ? 2 : (r == 2) ? 4 : 1;
    u    = (r == 5) ? 2 : (r == 6) ? 4 : 1;
    mult = (r == 4) ? 2 : 1;
    if ((pos % u) != 0) return 0;
    unit = pos / u;
    for (int k = 0; k < 13; k++) begin
      len = (k < 12 && (k % 3) == 0) ? 12 : 11;
      if (unit < len) return mult;
      if (unit == len) return 0;
      unit = unit - (len + 1);
    end
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_strobe = 1'b0;
    #1;
    check("R1", blk_count, 0);
    check("R1", sample_valid, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pos = 0;
    m_rate = 0;
    last_exp = 0;
  endtask

  task automatic do_frame(input int r, input int idle, output int obs);
    int e;
    @(negedge clk);
    rate_sel = 3'(r);
    frame_strobe = 1'b1;
    if (m_pos == 0) m_rate = (r == 7) ? 0 : r;  // R8 adoption at pattern start
    e = exp_blk(m_rate, m_pos);
    m_pos = (m_pos + 1) % period(m_rate);
    @(negedge clk);
    frame_strobe = 1'b0;
    check(tag(m_rate), blk_count, e);
    check("R9", sample_valid, (e != 0) ? 1 : 0);
    obs = blk_count;
    last_exp = e;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check("R2", blk_count, last_exp);
    end
  endtask

  task automatic run_sum(input int r, input int frames, input int exp_total, input string req);
    int o;
    do_reset();
    obs_sum = 0;
    for (int f = 0; f < frames; f++) begin
      do_frame(r, $urandom_range(0, 2), o);
      obs_sum += o;
    end
    check(req, obs_sum, exp_total);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int o;
    void'($urandom(32'h5eed_c0de));
    do_reset();                                 // R1 reset state
    // R3 fixed rates, including reserved code 7
    for (int r = 0; r < 3; r++)
      for (int f = 0; f < 6; f++) do_frame(r, 1, o);
    for (int f = 0; f < 6; f++) do_frame(7, 0, o);
    // R4: 3 patterns of 160 frames carry 441 samples
    run_sum(3, 480, 441, "R4");
    // R5: 294 blocks per 160 frames
    run_sum(4, 160, 294, "R5");
    // R6: 2 patterns of 320 frames
    run_sum(5, 640, 294, "R6");
    // R7: 1 pattern of 640 frames
    run_sum(6, 640, 147, "R7");
    // R8: mid-pattern change is ignored until the 44.1 pattern wraps
    do_reset();
    for (int f = 0; f < 50; f++) do_frame(3, 0, o);
    for (int f = 0; f < 110; f++) do_frame(2, 0, o);
    do_frame(2, 0, o);
    check("R8", o, 4);
    // R1: reset mid-pattern, the pattern restarts with a 12-frame run
    for (int f = 0; f < 20; f++) do_frame(3, 0, o);
    do_reset();
    obs_sum = 0;
    for (int f = 0; f < 13; f++) begin
      do_frame(3, 0, o);
      obs_sum += o;
    end
    check("R1", obs_sum, 12);
    // random rates and strobe spacing
    do_reset();
    begin
      int r = 3;
      for (int f = 0; f < 1500; f++) begin
        if ($urandom_range(0, 39) == 0) r = $urandom_range(0, 7);
        do_frame(r, $urandom_range(0, 3), o);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule